// File: doc/BRIEF.md
# Four-Channel Shared-Counter Pulse-Width Modulator

This block produces four pulse-width-modulated outputs from one period counter. A power-of-two prescaler divides the block clock into counter ticks. The counter either ramps from zero to a programmable top value and restarts (edge-aligned pulses), or ramps up to the top and back down (center-aligned pulses). Every channel compares its own 15-bit threshold against the counter. A sense bit carried in the same 16-bit duty word can invert the channel.

The surrounding sequencer presents the mode, divider code, top value and the four duty words on plain input buses. The block copies them into working registers only when a run starts and at each period boundary. The sequencer can therefore rewrite its inputs at any time without disturbing the period in progress; this also lets it change the top value for each step. A start pulse begins a run. A stop pulse lets the current period finish and then halts the block. A one-cycle strobe marks every period boundary, and a second strobe marks the boundary at which the run halted.

Top module: `pwm_quad`

## Requirements
- R1: The counter advances once every 2^`div_sel_i` clock cycles (codes 0..7 give division by 1, 2, 4 ... 128). The code is captured with the other settings at a period boundary.
- R2: With `center_i` = 0 the counter steps 0, 1, ... top and then restarts. A period lasts (top+1) ticks.
- R3: With `center_i` = 1 the counter steps 0, 1, ... top, top-1, ... 1. A period lasts 2·top ticks (1 tick when top is 0).
- R4: Duty word n occupies `duty_i[16n+15:16n]`. Bit 15 is the sense bit and bits 14..0 are the threshold. While running, `pwm_o[n]` is high when the counter is below the threshold, and the sense bit set inverts this.
- R5: A threshold of zero holds a channel at its inactive level for the whole period. A threshold greater than the top value holds it at its active level.
- R6: Mode, divider code, top value and duty words are captured on a start and at every period boundary. Changes made inside a period take effect only in the next period.
- R7: `period_end_o` is high for exactly one cycle, in the first cycle of the period that follows each completed period.
- R8: A stop pulse received while running takes effect at the end of the current period. `stopped_o` rises together with that period's `period_end_o`. Afterwards no more strobes occur and each output rests at its sense bit.
- R9: `start_i` has no effect while running, and `stop_i` has no effect while halted.
- R10: After reset the block is halted, and all outputs and strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start pulse; captures settings and begins a run when halted |
| stop_i | input | 1 | Stop request; honoured at the next period boundary |
| center_i | input | 1 | Counting mode: 0 edge-aligned, 1 center-aligned |
| div_sel_i | input | 3 | Prescaler code; division by 2^code |
| top_i | input | 15 | Counter top value |
| duty_i | input | 64 | Four duty words, channel n at bits 16n+15..16n |
| pwm_o | output | 4 | Channel outputs |
| period_end_o | output | 1 | One-cycle strobe at each period boundary |
| stopped_o | output | 1 | One-cycle strobe at the boundary where the run halted |

## Verification
Start is sampled at edge k. The strobe of the n-th period then appears in the cycle after edge k plus the sum of the first n period lengths, each length being the tick count times 2^code. `stopped_o` appears in that same cycle, and the outputs are combinational from registered state, so they are valid from the cycle after each edge. The bench computes each strobe's cycle number and each channel's high-cycle count per period from the requirement formulas, and queues them when the run is started. A monitor samples at the falling edge. It counts high cycles per channel between strobes and compares both the counts and the strobe cycle number against the next queued item. Inputs are changed two nanoseconds after a rising edge, so every stop request and every settings change falls in a known period.

// File: rtl/pwm_quad_pkg.sv
// Shared types for the four-channel modulator.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package pwm_quad_pkg;

    // Counter direction profile for one period.
    typedef enum logic {
        CNT_SAWTOOTH = 1'b0,  // ramp up, restart at zero
        CNT_TRIANGLE = 1'b1   // ramp up, then ramp down
    } cnt_mode_e;

    // Default widths, used by the top module parameters.
    localparam int DEF_NUM_CH = 4;
    localparam int DEF_CNT_W  = 15;
    localparam int DEF_DIV_W  = 3;

endpackage

// File: rtl/pwm_prescaler.sv
// Tick generator: divides the clock by 2^sel.
// Assumes: sel only changes while en is low or on the cycle a tick is issued,
// so the running count never exceeds the new terminal value.
module pwm_prescaler #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = (1 << DIV_W) - 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] term;

    // Terminal count: the low sel bits set.
    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            term[i] = (i < int'(sel));
        end
    end

    assign tick = en && (pre_cnt == term);

    // Free-running divider, cleared while idle and after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + PRE_W'(1);
        end
    end

    AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (pre_cnt <= term)) else $error("prescaler past terminal"); // R1

endmodule

// File: rtl/pwm_counter.sv
// Period counter: sawtooth 0..top or triangle 0..top..1, one step per tick.
// Raises wrap combinationally on the tick that closes a period.
// Assumes: top and mode change only when wrap is taken or run is low.
module pwm_counter
    import pwm_quad_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic falling;   // triangle mode, down-ramp half
    logic at_top;
    logic small_top; // top of 0 or 1: the triangle closes at its peak

    assign at_top    = (cnt >= top);
    assign small_top = (top <= CNT_W'(1));

    // Detect the final tick of the period.
    always_comb begin
        if (mode == CNT_SAWTOOTH) begin
            wrap = tick && at_top;
        end else if (!falling) begin
            wrap = tick && at_top && small_top;
        end else begin
            wrap = tick && (cnt <= CNT_W'(1));
        end
    end

    // Step the count and the ramp direction.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt     <= '0;
            falling <= 1'b0;
        end else if (tick) begin
            if (wrap) begin
                cnt     <= '0;
                falling <= 1'b0;
            end else if (falling) begin
                cnt <= cnt - CNT_W'(1);
            end else if (!at_top) begin
                cnt <= cnt + CNT_W'(1);
            end else begin
                falling <= 1'b1;
                cnt     <= top - CNT_W'(1);
            end
        end
    end

    AST_CNT_LE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= top)) else $error("counter above top"); // R2

    AST_SAW_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CNT_SAWTOOTH) |-> !falling) else $error("sawtooth ramping down"); // R3

endmodule

// File: rtl/pwm_channel.sv
// One output stage: compares the shared count with a threshold and applies
// the sense bit. Purely combinational.
// Assumes: cnt, thr and inv come from registers of the same clock domain.
module pwm_channel #(
    parameter int CNT_W = 15
) (
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] thr,
    input  logic             inv,
    output logic             out
);
    logic active;

    // Active while the count sits below the threshold.
    assign active = (cnt < thr);

    // Halted channels rest at the inactive level, which is the sense bit.
    assign out = run ? (active ^ inv) : inv;

endmodule

// File: rtl/pwm_quad.sv
// Four-channel pulse-width modulator on one shared counter.
// Holds the run state and the working copy of the settings, and captures the
// settings on start and at every period boundary. A stop request is kept
// pending until the boundary.
// Assumes: start_i and stop_i are synchronous to clk.
module pwm_quad
    import pwm_quad_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int CNT_W  = DEF_CNT_W,
    parameter int DIV_W  = DEF_DIV_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start_i,
    input  logic                            stop_i,
    input  logic                            center_i,
    input  logic [DIV_W-1:0]                div_sel_i,
    input  logic [CNT_W-1:0]                top_i,
    input  logic [NUM_CH*(CNT_W+1)-1:0]     duty_i,
    output logic [NUM_CH-1:0]               pwm_o,
    output logic                            period_end_o,
    output logic                            stopped_o
);
    localparam int DUTY_W = CNT_W + 1;

    logic                          running;
    logic                          stop_pend;
    cnt_mode_e                     wk_mode;
    logic [DIV_W-1:0]              wk_div;
    logic [CNT_W-1:0]              wk_top;
    logic [NUM_CH*DUTY_W-1:0]      wk_duty;

    logic                          tick;
    logic                          wrap;
    logic [CNT_W-1:0]              cnt;
    logic                          halt_now;
    logic                          capture;

    assign halt_now = wrap && (stop_pend || stop_i);
    assign capture  = (start_i && !running) || (wrap && !halt_now);

    // Run state, pending stop and the two strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running      <= 1'b0;
            stop_pend    <= 1'b0;
            period_end_o <= 1'b0;
            stopped_o    <= 1'b0;
        end else begin
            period_end_o <= wrap;
            stopped_o    <= halt_now;
            if (!running) begin
                running   <= start_i;
                stop_pend <= 1'b0;
            end else if (halt_now) begin
                running   <= 1'b0;
                stop_pend <= 1'b0;
            end else if (stop_i) begin
                stop_pend <= 1'b1;
            end
        end
    end

    // Working copy of the settings, refreshed only at boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_mode <= CNT_SAWTOOTH;
            wk_div  <= '0;
            wk_top  <= '0;
            wk_duty <= '0;
        end else if (capture) begin
            wk_mode <= cnt_mode_e'(center_i);
            wk_div  <= div_sel_i;
            wk_top  <= top_i;
            wk_duty <= duty_i;
        end
    end

    pwm_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (running),
        .sel   (wk_div),
        .tick  (tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .tick  (tick),
        .mode  (wk_mode),
        .top   (wk_top),
        .cnt   (cnt),
        .wrap  (wrap)
    );

    // One compare stage per channel, each fed from its duty word.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .run (running),
            .cnt (cnt),
            .thr (wk_duty[ch*DUTY_W +: CNT_W]),
            .inv (wk_duty[ch*DUTY_W + CNT_W]),
            .out (pwm_o[ch])
        );
    end

    AST_SETTINGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wrap) |=> ($stable(wk_duty) && $stable(wk_top)
                                && $stable(wk_div) && $stable(wk_mode)))
        else $error("settings changed inside a period"); // R6

    AST_STOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        stopped_o |-> period_end_o) else $error("halt off boundary"); // R8

    AST_QUIET_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stopped_o |=> !period_end_o) else $error("strobe after halt"); // R8

    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start_i) |=> !period_end_o) else $error("strobe while idle"); // R9

endmodule

// File: tb/tb_pwm_quad.sv
// Scoreboard bench: the driver queues the expected strobe cycle and per-channel
// high-cycle counts for each period; the monitor checks them as strobes arrive.
module tb_pwm_quad;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        stop_i = 1'b0;
    logic        center_i = 1'b0;
    logic [2:0]  div_sel_i = '0;
    logic [14:0] top_i = '0;
    logic [63:0] duty_i = '0;
    logic [3:0]  pwm_o;
    logic        period_end_o;
    logic        stopped_o;

    always #5 clk = ~clk;

    pwm_quad dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .center_i     (center_i),
        .div_sel_i    (div_sel_i),
        .top_i        (top_i),
        .duty_i       (duty_i),
        .pwm_o        (pwm_o),
        .period_end_o (period_end_o),
        .stopped_o    (stopped_o)
    );

    typedef struct {
        bit center;
        int sel;
        int top;
        int cmp [NCH];
        bit pol [NCH];
    } tcfg_t;

    typedef struct {
        int    cyc;
        int    hi [NCH];
        bit    stop;
        string tag;
    } exp_t;

    exp_t  sb_q [$];
    int    cyc = 0;
    int    drv_checks = 0, drv_fails = 0;
    int    mon_checks = 0, mon_fails = 0;
    int    wd_fails = 0;
    int    seen = 0;
    int    arm_req = 0;
    int    arm_seen = 0;
    int    acc [NCH];
    int    pe_base = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic tcfg_t mk(bit c, int s, int t, int c0, int c1, int c2, int c3,
                                 bit p0, bit p1, bit p2, bit p3);
        tcfg_t r;
        r.center = c; r.sel = s; r.top = t;
        r.cmp[0] = c0; r.cmp[1] = c1; r.cmp[2] = c2; r.cmp[3] = c3;
        r.pol[0] = p0; r.pol[1] = p1; r.pol[2] = p2; r.pol[3] = p3;
        return r;
    endfunction

    task automatic chk_d(bit ok, string req, string what, int act, int exp);
        drv_checks++;
        if (!ok) begin
            drv_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_m(bit ok, string req, string what, int act, int exp);
        mon_checks++;
        if (!ok) begin
            mon_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply(tcfg_t c);
        center_i  = c.center;
        div_sel_i = 3'(c.sel);
        top_i     = 15'(c.top);
        for (int i = 0; i < NCH; i++) begin
            duty_i[i*16 +: 16] = {c.pol[i], 15'(c.cmp[i])};
        end
    endtask

    // Period length and high counts from the R1..R5 formulas.
    task automatic expect_period(tcfg_t c, bit stop, string tag);
        exp_t e;
        int d, ticks, act;
        d = 1 << c.sel;
        if (!c.center) ticks = c.top + 1;
        else           ticks = (c.top == 0) ? 1 : 2 * c.top;
        for (int i = 0; i < NCH; i++) begin
            if (!c.center) begin
                act = (c.cmp[i] < c.top + 1) ? c.cmp[i] : c.top + 1;
            end else if (c.cmp[i] == 0) begin
                act = 0;
            end else if (c.cmp[i] > c.top) begin
                act = ticks;
            end else begin
                act = 2 * c.cmp[i] - 1;
            end
            e.hi[i] = c.pol[i] ? (ticks - act) * d : act * d;
        end
        pe_base = pe_base + ticks * d;
        e.cyc  = pe_base;
        e.stop = stop;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    task automatic begin_run(tcfg_t c, bit stop_now);
        apply(c);
        @(posedge clk); #2;
        pe_base = cyc + 1;
        start_i = 1'b1;
        @(posedge clk); #2;
        start_i = 1'b0;
        stop_i  = stop_now;
        arm_req++;
        @(posedge clk); #2;
        stop_i  = 1'b0;
    endtask

    task automatic wait_seen(int n);
        while (seen < n) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic pulse_stop();
        stop_i = 1'b1;
        @(posedge clk); #2;
        stop_i = 1'b0;
    endtask

    // Halted: no strobes, each output at its sense bit (R8).
    task automatic check_idle(tcfg_t c, int n);
        logic [3:0] lvl;
        for (int i = 0; i < NCH; i++) lvl[i] = c.pol[i];
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #2;
            chk_d(pwm_o == lvl, "R8", "idle output level", int'(pwm_o), int'(lvl));
            chk_d(!period_end_o && !stopped_o, "R8", "strobe while halted",
                  int'({period_end_o, stopped_o}), 0);
        end
    endtask

    // Monitor: count high cycles, score them at each strobe.
    always @(negedge clk) begin
        if (rst_n) begin
            if (arm_req != arm_seen) begin
                arm_seen = arm_req;
                for (int i = 0; i < NCH; i++) acc[i] = 0;
            end
            if (period_end_o) begin
                seen = seen + 1;
                if (sb_q.size() == 0) begin
                    chk_m(1'b0, "R7", "unexpected period strobe", cyc, -1);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk_m(cyc == e.cyc, e.tag, "strobe cycle R7", cyc, e.cyc);
                    for (int i = 0; i < NCH; i++) begin
                        chk_m(acc[i] == e.hi[i], "R4/R5", "high cycles per period",
                              acc[i], e.hi[i]);
                    end
                    chk_m(stopped_o == e.stop, "R8", "halt strobe",
                          int'(stopped_o), int'(e.stop));
                end
                for (int i = 0; i < NCH; i++) acc[i] = 0;
            end
            for (int i = 0; i < NCH; i++) acc[i] = acc[i] + int'(pwm_o[i]);
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d",
                 drv_checks + mon_checks + wd_fails, drv_fails + mon_fails + wd_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            wd_fails = 1;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            summary();
        end
    end

    initial begin
        tcfg_t c1, c2, c3a, c3b, c4, c5, c6;
        int base;
        c1  = mk(1'b0, 0, 9, 3, 0, 12, 5, 1'b0, 1'b0, 1'b0, 1'b1);
        c2  = mk(1'b1, 2, 6, 6, 1, 7, 3, 1'b0, 1'b1, 1'b1, 1'b0);
        c3a = mk(1'b0, 1, 7, 2, 4, 8, 0, 1'b0, 1'b1, 1'b0, 1'b1);
        c3b = mk(1'b0, 0, 4, 1, 5, 4, 2, 1'b1, 1'b0, 1'b0, 1'b0);
        c4  = mk(1'b0, 7, 3, 2, 0, 4, 3, 1'b0, 1'b0, 1'b0, 1'b1);
        c5  = mk(1'b1, 0, 1, 1, 0, 2, 1, 1'b0, 1'b0, 1'b0, 1'b1);
        c6  = mk(1'b0, 0, 0, 0, 1, 0, 3, 1'b0, 1'b0, 1'b1, 1'b0);

        // R10: reset state
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        chk_d(pwm_o == 4'b0, "R10", "pwm after reset", int'(pwm_o), 0);
        chk_d(!period_end_o, "R10", "period strobe after reset", int'(period_end_o), 0);
        chk_d(!stopped_o, "R10", "halt strobe after reset", int'(stopped_o), 0);
        repeat (3) @(posedge clk); #2;

        // R2, R4, R5: sawtooth, no division, three periods, halt in the third
        base = seen;
        begin_run(c1, 1'b0);
        expect_period(c1, 1'b0, "R2");
        expect_period(c1, 1'b0, "R2");
        expect_period(c1, 1'b1, "R2");
        wait_seen(base + 2);
        pulse_stop();
        wait_seen(base + 3);
        check_idle(c1, 20);

        // R3, R1: triangle, divide by 4, two periods
        base = seen;
        begin_run(c2, 1'b0);
        expect_period(c2, 1'b0, "R3/R1");
        expect_period(c2, 1'b1, "R3/R1");
        wait_seen(base + 1);
        pulse_stop();
        wait_seen(base + 2);
        check_idle(c2, 20);

        // R9: stop while halted is ignored; the next run must not halt early
        pulse_stop();
        repeat (3) @(posedge clk); #2;
        // R6: settings rewritten inside period 1 land in period 2
        base = seen;
        begin_run(c3a, 1'b0);
        apply(c3b);
        expect_period(c3a, 1'b0, "R6/R9");
        expect_period(c3b, 1'b0, "R6");
        expect_period(c3b, 1'b1, "R6/R9");
        wait_seen(base + 1);
        start_i = 1'b1;          // R9: start while running is ignored
        @(posedge clk); #2;
        start_i = 1'b0;
        wait_seen(base + 2);
        pulse_stop();
        wait_seen(base + 3);
        check_idle(c3b, 10);

        // R1: largest divider, halt requested in the first period
        base = seen;
        begin_run(c4, 1'b1);
        expect_period(c4, 1'b1, "R1");
        wait_seen(base + 1);
        check_idle(c4, 10);

        // R3: triangle with top 1 (two ticks per period)
        base = seen;
        begin_run(c5, 1'b1);
        expect_period(c5, 1'b1, "R3");
        wait_seen(base + 1);
        check_idle(c5, 10);

        // R2: sawtooth with top 0 (one tick per period)
        base = seen;
        begin_run(c6, 1'b1);
        expect_period(c6, 1'b1, "R2");
        wait_seen(base + 1);
        check_idle(c6, 10);

        chk_d(sb_q.size() == 0, "R7", "expected strobes left unseen", sb_q.size(), 0);
        done = 1'b1;
        summary();
    end

endmodule